// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether a received Ethernet frame is kept or dropped. The destination address reaches it already deserialized, one byte per cycle, with a strobe on the first byte. The block compares those bytes against a programmed station address and classifies the destination as own, broadcast or multicast. When the end-of-frame strobe arrives with the frame length, the CRC verdict and a reset-frame flag, the block combines that classification with a receive-mode byte and pulses exactly one of accept or reject. It also pulses status strobes for good packets, runt frames and delivered reset frames.

Configuration is a set of byte-wide write-only registers. The station address sits at six consecutive offsets and the mode byte sits at its own offset. The mode byte is captured when a frame's first address byte arrives, so software can change it at any time without disturbing a frame that is already in progress. Deserialization, CRC computation and packet storage belong to neighbouring blocks.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, accept, reject, good_pkt, runt_evt and reset_evt are all low, and they stay low until an end-of-frame strobe is seen.
- R2: A write to offset 8+k (k = 0..5) sets station byte k, and byte k is compared with the k-th received destination byte (first received = k 0). A write to offset 5 sets the mode byte. Writes to any other offset change no behaviour.
- R3: One cycle after eof_valid, exactly one of accept and reject is high for one cycle. Neither is high in any cycle that does not follow an eof_valid.
- R4: With mode bits [1:0] = 0, every frame is rejected.
- R5: With mode bits [1:0] = 1, a frame passes the address test only when its destination equals the station address or is all 0xFF (broadcast).
- R6: With mode bits [1:0] = 2, a frame whose first destination byte has bit 0 set (multicast) also passes, in addition to the frames of R5.
- R7: With mode bits [1:0] = 3, every frame passes the address test.
- R8: With mode bit 4 set, the own-address comparison uses only destination bytes 0..4. Byte 5 is ignored.
- R9: A frame with a length below 64 is a runt. A runt is rejected unless mode bit 3 is set. runt_evt pulses with the decision for every runt, whether it is accepted or rejected.
- R10: A frame flagged as a reset frame is rejected unless mode bit 2 is set. reset_evt pulses only when such a frame is accepted.
- R11: good_pkt pulses with the decision exactly when the frame is accepted and its CRC flag is good.
- R12: The mode byte is sampled on the first destination byte of each frame. A mode write during a frame takes effect only from the next frame.
- R13: Mode bits 7..5 have no effect on any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| da_valid | input | 1 | A destination address byte is present |
| da_first | input | 1 | Marks the first destination byte of a frame (with da_valid) |
| da_byte | input | 8 | Destination address byte |
| eof_valid | input | 1 | End-of-frame strobe |
| eof_len | input | 11 | Frame length in bytes, valid with eof_valid |
| eof_crc_ok | input | 1 | CRC of the frame was good, valid with eof_valid |
| eof_reset_frm | input | 1 | Frame is a reset frame, valid with eof_valid |
| accept | output | 1 | Frame accepted (one-cycle pulse) |
| reject | output | 1 | Frame rejected (one-cycle pulse) |
| good_pkt | output | 1 | Accepted frame with good CRC (pulse) |
| runt_evt | output | 1 | Frame was a runt (pulse) |
| reset_evt | output | 1 | Reset frame was accepted (pulse) |

## Verification
The assertions assume that frames arrive one at a time. They also assume that eof_valid is a single-cycle strobe that comes at least one cycle after the sixth destination byte and never together with a destination byte. The bench keeps within this by driving each frame as six consecutive address bytes, then one end-of-frame cycle, then one idle cycle before the next frame. It writes the station address only between frames. The only configuration write it makes during a frame is the mode write that R12 exercises.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

   typedef enum logic [1:0] {
      LVL_NONE   = 2'd0,
      LVL_UNI_BC = 2'd1,
      LVL_MCAST  = 2'd2,
      LVL_ALL    = 2'd3
   } level_e;

   typedef struct packed {
      logic [2:0] spare;
      logic       part_cmp;
      logic       take_runt;
      logic       take_reset;
      level_e     level;
   } mode_t;

endpackage

// File: rtl/rdf_cfg_regs.sv
module rdf_cfg_regs #(
   parameter int ADDR_BYTES = 6,
   parameter int CFG_AW     = 4,
   parameter int STA_BASE   = 8,
   parameter int MODE_OFS   = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [CFG_AW-1:0]           cfg_addr,
   input  logic [7:0]                  cfg_wdata,
   output logic [ADDR_BYTES-1:0][7:0]  sta,
   output logic [7:0]                  mode_reg
);

   localparam int SPAN = 1 << CFG_AW;

   if (STA_BASE + ADDR_BYTES > SPAN) begin : g_bad_span
      $error("station address does not fit the register space");
   end
   if (MODE_OFS >= STA_BASE && MODE_OFS < STA_BASE + ADDR_BYTES) begin : g_bad_mode
      $error("mode offset overlaps station address");
   end

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_sta
      always_ff @(posedge clk) begin
         if (!rst_n)
            sta[i] <= '0;
         else if (cfg_we && cfg_addr == CFG_AW'(STA_BASE + i))
            sta[i] <= cfg_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_reg <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(MODE_OFS))
         mode_reg <= cfg_wdata;
   end

endmodule

// File: rtl/rdf_addr_match.sv
module rdf_addr_match #(
   parameter int ADDR_BYTES = 6,
   parameter int PART_BYTES = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        da_valid,
   input  logic                        da_first,
   input  logic [7:0]                  da_byte,
   input  logic [ADDR_BYTES-1:0][7:0]  sta,
   input  logic                        part_en,
   output logic                        own_hit,
   output logic                        bcast_hit,
   output logic                        mcast_hit
);

   localparam int CW = $clog2(ADDR_BYTES + 1);

   if (PART_BYTES >= ADDR_BYTES || PART_BYTES < 0) begin : g_bad_part
      $error("partial match width must be below the address width");
   end

   logic [CW-1:0]         cnt_q;
   logic [CW-1:0]         cur_idx;
   logic [ADDR_BYTES-1:0] eq_q;
   logic                  bc_q;
   logic                  mc_q;
   logic                  complete;
   logic                  own_full;

   assign cur_idx = da_first ? '0 : cnt_q;

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n)
            eq_q[i] <= 1'b0;
         else if (da_valid && cur_idx == CW'(i))
            eq_q[i] <= (da_byte == sta[i]);
         else if (da_valid && da_first)
            eq_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         bc_q  <= 1'b0;
         mc_q  <= 1'b0;
      end else if (da_valid && da_first) begin
         cnt_q <= CW'(1);
         bc_q  <= (da_byte == 8'hFF);
         mc_q  <= da_byte[0];
      end else if (da_valid && cnt_q < CW'(ADDR_BYTES)) begin
         cnt_q <= cnt_q + CW'(1);
         bc_q  <= bc_q & (da_byte == 8'hFF);
      end
   end

   assign complete  = (cnt_q == CW'(ADDR_BYTES));
   assign own_full  = complete & (&eq_q);
   assign bcast_hit = complete & bc_q;
   assign mcast_hit = (cnt_q != '0) & mc_q;

   if (PART_BYTES > 0) begin : g_part
      logic own_part;
      assign own_part = complete & (&eq_q[PART_BYTES-1:0]);
      assign own_hit  = part_en ? own_part : own_full;
   end else begin : g_full_only
      assign own_hit = own_full;
   end

endmodule

// File: rtl/rdf_decide.sv
module rdf_decide
   import rdf_pkg::*;
#(
   parameter int LEN_W   = 11,
   parameter int MIN_LEN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mode_t            mode,
   input  logic             own_hit,
   input  logic             bcast_hit,
   input  logic             mcast_hit,
   input  logic             eof_valid,
   input  logic [LEN_W-1:0] eof_len,
   input  logic             eof_crc_ok,
   input  logic             eof_reset_frm,
   output logic             accept,
   output logic             reject,
   output logic             good_pkt,
   output logic             runt_evt,
   output logic             reset_evt
);

   if (MIN_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("runt threshold does not fit the length field");
   end

   logic addr_pass;
   logic is_runt;
   logic take;

   always_comb begin
      unique case (mode.level)
         LVL_NONE:   addr_pass = 1'b0;
         LVL_UNI_BC: addr_pass = own_hit | bcast_hit;
         LVL_MCAST:  addr_pass = own_hit | bcast_hit | mcast_hit;
         LVL_ALL:    addr_pass = 1'b1;
         default:    addr_pass = 1'b0;
      endcase
   end

   assign is_runt = (eof_len < LEN_W'(MIN_LEN));
   assign take    = addr_pass & (~is_runt | mode.take_runt)
                              & (~eof_reset_frm | mode.take_reset);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         accept    <= 1'b0;
         reject    <= 1'b0;
         good_pkt  <= 1'b0;
         runt_evt  <= 1'b0;
         reset_evt <= 1'b0;
      end else begin
         accept    <= eof_valid & take;
         reject    <= eof_valid & ~take;
         good_pkt  <= eof_valid & take & eof_crc_ok;
         runt_evt  <= eof_valid & is_runt;
         reset_evt <= eof_valid & take & eof_reset_frm;
      end
   end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
   import rdf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int PART_BYTES = 5,
   parameter int MIN_LEN    = 64,
   parameter int LEN_W      = 11,
   parameter int CFG_AW     = 4,
   parameter int STA_BASE   = 8,
   parameter int MODE_OFS   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic              da_valid,
   input  logic              da_first,
   input  logic [7:0]        da_byte,
   input  logic              eof_valid,
   input  logic [LEN_W-1:0]  eof_len,
   input  logic              eof_crc_ok,
   input  logic              eof_reset_frm,
   output logic              accept,
   output logic              reject,
   output logic              good_pkt,
   output logic              runt_evt,
   output logic              reset_evt
);

   logic [ADDR_BYTES-1:0][7:0] sta;
   logic [7:0]                 mode_reg;
   mode_t                      mode_q;
   logic [1:0]                 lvl_q;
   logic                       own_hit;
   logic                       bcast_hit;
   logic                       mcast_hit;

   rdf_cfg_regs #(
      .ADDR_BYTES(ADDR_BYTES), .CFG_AW(CFG_AW),
      .STA_BASE(STA_BASE), .MODE_OFS(MODE_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .sta(sta), .mode_reg(mode_reg)
   );

   // mode is latched when a frame begins
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= mode_t'(8'h00);
      else if (da_valid && da_first)
         mode_q <= mode_t'(mode_reg);
   end

   assign lvl_q = mode_q.level;

   rdf_addr_match #(
      .ADDR_BYTES(ADDR_BYTES), .PART_BYTES(PART_BYTES)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_first(da_first),
      .da_byte(da_byte), .sta(sta), .part_en(mode_q.part_cmp),
      .own_hit(own_hit), .bcast_hit(bcast_hit), .mcast_hit(mcast_hit)
   );

   rdf_decide #(
      .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
   ) u_decide (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .own_hit(own_hit),
      .bcast_hit(bcast_hit), .mcast_hit(mcast_hit), .eof_valid(eof_valid),
      .eof_len(eof_len), .eof_crc_ok(eof_crc_ok), .eof_reset_frm(eof_reset_frm),
      .accept(accept), .reject(reject), .good_pkt(good_pkt),
      .runt_evt(runt_evt), .reset_evt(reset_evt)
   );

endmodule

// File: rtl/rdf_checker.sv
module rdf_checker #(
   parameter int LEN_W   = 11,
   parameter int MIN_LEN = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eof_valid,
   input logic [LEN_W-1:0] eof_len,
   input logic [1:0]       lvl_q,
   input logic             accept,
   input logic             reject,
   input logic             good_pkt,
   input logic             runt_evt,
   input logic             reset_evt
);

   a_r3_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
      eof_valid |=> (accept ^ reject));

   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (accept || reject) |-> $past(eof_valid));

   a_r4_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && lvl_q == 2'd0) |=> reject);

   a_r9_runt_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (eof_valid && eof_len < LEN_W'(MIN_LEN)) |=> runt_evt);

   a_r9_runt_only: assert property (@(posedge clk) disable iff (!rst_n)
      runt_evt |-> ($past(eof_valid) && $past(eof_len) < LEN_W'(MIN_LEN)));

   a_r10_reset_delivered: assert property (@(posedge clk) disable iff (!rst_n)
      reset_evt |-> accept);

   a_r11_good_implies_accept: assert property (@(posedge clk) disable iff (!rst_n)
      good_pkt |-> accept);

endmodule

bind rx_dest_filter rdf_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_len(eof_len),
   .lvl_q(lvl_q), .accept(accept), .reject(reject), .good_pkt(good_pkt),
   .runt_evt(runt_evt), .reset_evt(reset_evt)
);

// File: tb/rx_dest_filter_test.sv
`timescale 1ns/1ps
module rx_dest_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        da_valid = 1'b0;
   logic        da_first = 1'b0;
   logic [7:0]  da_byte = '0;
   logic        eof_valid = 1'b0;
   logic [10:0] eof_len = '0;
   logic        eof_crc_ok = 1'b0;
   logic        eof_reset_frm = 1'b0;
   logic        accept, reject, good_pkt, runt_evt, reset_evt;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] own [6] = '{8'h02, 8'h07, 8'h01, 8'h3C, 8'h5A, 8'h96};

   always #2 clk = ~clk;

   rx_dest_filter uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_first(da_first),
      .da_byte(da_byte), .eof_valid(eof_valid), .eof_len(eof_len),
      .eof_crc_ok(eof_crc_ok), .eof_reset_frm(eof_reset_frm),
      .accept(accept), .reject(reject), .good_pkt(good_pkt),
      .runt_evt(runt_evt), .reset_evt(reset_evt)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // kinds: 0 own, 1 own with last byte changed, 2 own with first byte
   // changed, 3 broadcast, 4 multicast, 5 foreign unicast
   function automatic logic [7:0] dbyte(input int kind, input int k);
      logic [7:0] mc [6] = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
      logic [7:0] fu [6] = '{8'h04, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      case (kind)
         0: return own[k];
         1: return (k == 5) ? (own[k] ^ 8'h01) : own[k];
         2: return (k == 0) ? (own[k] ^ 8'h80) : own[k];
         3: return 8'hFF;
         4: return mc[k];
         default: return fu[k];
      endcase
   endfunction

   // sends one frame; optionally writes the mode byte during address byte 2
   task automatic send(input int kind, input int len, input bit crc,
                       input bit rf, input bit mid, input logic [7:0] mid_val);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         da_valid = 1'b1; da_first = (k == 0); da_byte = dbyte(kind, k);
         cfg_we = mid && (k == 2); cfg_addr = 4'd5; cfg_wdata = mid_val;
      end
      @(negedge clk);
      cfg_we = 1'b0; da_valid = 1'b0; da_first = 1'b0;
      eof_valid = 1'b1; eof_len = 11'(len); eof_crc_ok = crc; eof_reset_frm = rf;
      @(negedge clk);
      eof_valid = 1'b0;
   endtask

   function automatic bit exp_acc(input int lvl, input bit part, input bit er,
                                  input bit erst, input int kind, input int len,
                                  input bit rf);
      bit own_m, bc, mc, pass;
      own_m = (kind == 0) || (part && kind == 1);
      bc    = (kind == 3);
      mc    = (kind == 3) || (kind == 4);
      case (lvl)
         0: pass = 0;
         1: pass = own_m || bc;
         2: pass = own_m || bc || mc;
         default: pass = 1;
      endcase
      return pass && (len >= 64 || er) && (!rf || erst);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      string tg;
      bit e;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 accept", accept, 1'b0);
      chk("R1 reject", reject, 1'b0);
      chk("R1 good_pkt", good_pkt, 1'b0);
      chk("R1 runt_evt", runt_evt, 1'b0);
      chk("R1 reset_evt", reset_evt, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", accept | reject, 1'b0);

      for (int i = 0; i < 6; i++) wr(4'(8 + i), own[i]);

      // sweep over the mode fields and frame attributes
      for (int lvl = 0; lvl < 4; lvl++)
      for (int part = 0; part < 2; part++)
      for (int er = 0; er < 2; er++)
      for (int erst = 0; erst < 2; erst++) begin
         wr(4'd5, 8'(lvl | (erst << 2) | (er << 3) | (part << 4)));
         for (int kind = 0; kind < 6; kind++)
         for (int li = 0; li < 2; li++)
         for (int rf = 0; rf < 2; rf++)
         for (int crc = 0; crc < 2; crc++) begin
            send(kind, 63 + li, crc[0], rf[0], 1'b0, 8'h00);
            e = exp_acc(lvl, part[0], er[0], erst[0], kind, 63 + li, rf[0]);
            if (part == 1 && kind == 1 && lvl inside {1, 2}) tg = "R8 partial match";
            else if (lvl == 0) tg = "R4 level none";
            else if (lvl == 1) tg = "R5 own/broadcast";
            else if (lvl == 2) tg = "R6 multicast";
            else tg = "R7 all";
            chk(tg, accept, e);
            chk("R3 reject complements accept", reject, !e);
            chk("R9 runt strobe", runt_evt, li == 0);
            chk("R10 reset strobe", reset_evt, e && rf == 1);
            chk("R11 good packet", good_pkt, e && crc == 1);
            @(negedge clk);
            chk("R3 single pulse", accept | reject, 1'b0);
         end
      end

      // R2: station byte 1 changed -> own frame no longer matches
      wr(4'd5, 8'h01);
      wr(4'd9, 8'hAA);
      send(0, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R2 station byte at offset 9", accept, 1'b0);
      wr(4'd9, own[1]);
      send(0, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R2 station byte restored", accept, 1'b1);
      // R2: writes to unused offsets have no effect
      wr(4'd0, 8'h03); wr(4'd14, 8'h00); wr(4'd15, 8'h00); wr(4'd4, 8'h03);
      send(5, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R2 unused offsets ignored (mode)", accept, 1'b0);
      send(0, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R2 unused offsets ignored (station)", accept, 1'b1);

      // R12: mode written mid-frame only affects the next frame
      wr(4'd5, 8'h00);
      send(3, 100, 1'b1, 1'b0, 1'b1, 8'h01);
      chk("R12 mid-frame write deferred", accept, 1'b0);
      send(3, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R12 new mode on next frame", accept, 1'b1);
      send(5, 100, 1'b1, 1'b0, 1'b1, 8'h03);
      chk("R12 deferred widening", accept, 1'b0);
      send(5, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R12 widened mode applies", accept, 1'b1);

      // R13: upper mode bits have no effect
      wr(4'd5, 8'hE1);
      send(0, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R13 spare bits, own frame", accept, 1'b1);
      send(5, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R13 spare bits, foreign frame", accept, 1'b0);
      send(4, 100, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R13 spare bits, multicast", accept, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule